// File: doc/BRIEF.md
# Crosspoint Switch Control Latch Array

This block stores the on/off command for each switch of a 4-row by 8-column analog crosspoint matrix, so it holds 32 control bits. A 2-bit row address and a 3-bit column address pick one crosspoint. A strobe pulse together with a chip select and a data bit writes that one crosspoint. A master clear turns every switch off. The 32-bit enable vector drives the switch gates directly.

All control inputs are treated as asynchronous to the system clock. Strobe, master clear and the data bit each pass through a synchroniser. Edges of the strobe are detected inside the block. The address and chip select are captured on the rising strobe edge. The data bit is taken at the falling strobe edge, and the write is committed there. Matrix size and synchroniser depth are parameters.

Top module: `xpt_latch_array`

## Requirements
- R1: After the system reset `rst_n` is released, all 32 enables read 0.
- R2: A strobe pulse with `chip_sel`=1 writes `wr_data` into the crosspoint at row `row_sel`, column `col_sel`. 1 turns the enable on and 0 turns it off. The enable for row r, column c is bit r*8+c of `sw_en`.
- R3: A strobe pulse with `chip_sel`=0 leaves every enable unchanged.
- R4: Nothing is committed while strobe stays high. The enables change only after the strobe falls.
- R5: The value written is the data bit present at the falling edge of the strobe. A value present only earlier in the pulse is not written.
- R6: Holding `master_clr` high turns all 32 enables off, whatever the state of `chip_sel`.
- R7: A write changes only the addressed bit. The other 31 bits keep their values.
- R8: When a master clear and a strobe fall arrive together, the clear wins and all enables read 0.
- R9: The address is taken at the rising edge of the strobe. An address change while strobe is high has no effect on which crosspoint is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset (power-up) |
| strobe | input | 1 | Write strobe, active high, asynchronous |
| chip_sel | input | 1 | Chip select, active high |
| wr_data | input | 1 | Switch state to write (1 = on) |
| row_sel | input | 2 | Row address |
| col_sel | input | 3 | Column address |
| master_clr | input | 1 | Master clear, active high, asynchronous |
| sw_en | output | 32 | Switch enables, bit r*8+c for row r, column c |

## Verification
The assertions assume that the address and chip select are stable across the rising strobe edge. They also assume that the data bit holds for a few clock cycles after the strobe falls, long enough to cross the synchroniser beside the strobe. The stimulus sets address, chip select and data at least one cycle before raising the strobe. It keeps strobe high for four cycles and holds all inputs for six cycles after the fall. A change in the middle of a pulse happens only in the tests that check the data bit is taken at the fall and the address at the rise. Master clear pulses last four cycles. The one pulse that coincides with a strobe fall is driven on the same clock phase as that fall.

// File: rtl/xpt_pkg.sv
package xpt_pkg;

   // Flat position of one crosspoint inside the enable vector.
   function automatic int xpt_flat_index(input int row, input int col, input int cols);
      return row * cols + col;
   endfunction

endpackage

// File: rtl/xpt_sync.sv
module xpt_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] d_sync
);

   logic [WIDTH-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign d_sync = chain[STAGES-1];

endmodule

// File: rtl/xpt_strobe_ctrl.sv
module xpt_strobe_ctrl
   import xpt_pkg::*;
#(
   parameter int ROWS = 4,
   parameter int COLS = 8,
   localparam int RA_W  = $clog2(ROWS),
   localparam int CA_W  = $clog2(COLS),
   localparam int IDX_W = $clog2(ROWS * COLS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stb_s,
   input  logic             data_s,
   input  logic             chip_sel,
   input  logic [RA_W-1:0]  row_sel,
   input  logic [CA_W-1:0]  col_sel,
   output logic             stb_fall,
   output logic             cs_cap,
   output logic             wr_en,
   output logic [IDX_W-1:0] wr_idx,
   output logic             wr_bit
);

   logic            stb_prev;
   logic            stb_rise;
   logic [RA_W-1:0] row_cap;
   logic [CA_W-1:0] col_cap;

   assign stb_rise = stb_s & ~stb_prev;
   assign stb_fall = ~stb_s & stb_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stb_prev <= 1'b0;
         row_cap  <= '0;
         col_cap  <= '0;
         cs_cap   <= 1'b0;
      end else begin
         stb_prev <= stb_s;
         if (stb_rise) begin
            row_cap <= row_sel;
            col_cap <= col_sel;
            cs_cap  <= chip_sel;
         end
      end
   end

   assign wr_en  = stb_fall & cs_cap;
   assign wr_idx = IDX_W'(xpt_flat_index(int'(row_cap), int'(col_cap), COLS));
   assign wr_bit = data_s;

endmodule

// File: rtl/xpt_cell_bank.sv
module xpt_cell_bank #(
   parameter int N = 32,
   localparam int IDX_W = $clog2(N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_bit,
   output logic [N-1:0]     cells
);

   generate
      for (genvar i = 0; i < N; i++) begin : g_cell
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  cells[i] <= 1'b0;
            else if (clr)                                cells[i] <= 1'b0;
            else if (wr_en && (wr_idx == IDX_W'(i)))     cells[i] <= wr_bit;
         end
      end
   endgenerate

endmodule

// File: rtl/xpt_latch_array.sv
module xpt_latch_array #(
   parameter int ROWS        = 4,
   parameter int COLS        = 8,
   parameter int SYNC_STAGES = 2,
   localparam int RA_W  = $clog2(ROWS),
   localparam int CA_W  = $clog2(COLS),
   localparam int N     = ROWS * COLS,
   localparam int IDX_W = $clog2(N)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            strobe,
   input  logic            chip_sel,
   input  logic            wr_data,
   input  logic [RA_W-1:0] row_sel,
   input  logic [CA_W-1:0] col_sel,
   input  logic            master_clr,
   output logic [N-1:0]    sw_en
);

   generate
      if (ROWS < 2 || (1 << RA_W) != ROWS) begin : g_bad_rows
         $error("ROWS must be a power of two of at least 2");
      end
      if (COLS < 2 || (1 << CA_W) != COLS) begin : g_bad_cols
         $error("COLS must be a power of two of at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (N > 4096) begin : g_bad_size
         $error("matrix too large");
      end
   endgenerate

   logic [2:0]       raw_bus;
   logic [2:0]       sync_bus;
   logic             stb_s;
   logic             clr_s;
   logic             data_s;
   logic             stb_fall;
   logic             cs_cap;
   logic             wr_en;
   logic [IDX_W-1:0] wr_idx;
   logic             wr_bit;

   assign raw_bus = {master_clr, wr_data, strobe};
   assign stb_s   = sync_bus[0];
   assign data_s  = sync_bus[1];
   assign clr_s   = sync_bus[2];

   xpt_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (raw_bus),
      .d_sync  (sync_bus)
   );

   xpt_strobe_ctrl #(.ROWS(ROWS), .COLS(COLS)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .stb_s    (stb_s),
      .data_s   (data_s),
      .chip_sel (chip_sel),
      .row_sel  (row_sel),
      .col_sel  (col_sel),
      .stb_fall (stb_fall),
      .cs_cap   (cs_cap),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_bit   (wr_bit)
   );

   xpt_cell_bank #(.N(N)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr_s),
      .wr_en  (wr_en),
      .wr_idx (wr_idx),
      .wr_bit (wr_bit),
      .cells  (sw_en)
   );

endmodule

// File: rtl/xpt_latch_array_chk.sv
module xpt_latch_array_chk #(
   parameter int N     = 32,
   parameter int IDX_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clr_s,
   input logic             stb_fall,
   input logic             cs_cap,
   input logic [IDX_W-1:0] wr_idx,
   input logic             wr_bit,
   input logic [N-1:0]     sw_en
);

   AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      clr_s |=> (sw_en == '0)); // R6

   AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_s && stb_fall) |=> (sw_en == '0)); // R8

   AST_SINGLE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_s |=> ($countones(sw_en ^ $past(sw_en)) <= 1)); // R7

   AST_HOLD_NO_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_s && !stb_fall) |=> $stable(sw_en)); // R4

   AST_CS_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_s && stb_fall && !cs_cap) |=> $stable(sw_en)); // R3

   AST_WRITE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_s && stb_fall && cs_cap) |=> (sw_en[$past(wr_idx)] == $past(wr_bit))); // R2

endmodule

bind xpt_latch_array xpt_latch_array_chk #(.N(N), .IDX_W(IDX_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .clr_s    (clr_s),
   .stb_fall (stb_fall),
   .cs_cap   (cs_cap),
   .wr_idx   (wr_idx),
   .wr_bit   (wr_bit),
   .sw_en    (sw_en)
);

// File: tb/test_xpt_latch_array.sv
`timescale 1ns/1ps
module test_xpt_latch_array;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        strobe = 1'b0;
   logic        chip_sel = 1'b0;
   logic        wr_data = 1'b0;
   logic [1:0]  row_sel = '0;
   logic [2:0]  col_sel = '0;
   logic        master_clr = 1'b0;
   logic [31:0] sw_en;

   logic [31:0] model = '0;
   int          checks = 0;
   int          errors = 0;

   always #2.5 clk = ~clk;

   xpt_latch_array i_xpt_latch_array (
      .clk        (clk),
      .rst_n      (rst_n),
      .strobe     (strobe),
      .chip_sel   (chip_sel),
      .wr_data    (wr_data),
      .row_sel    (row_sel),
      .col_sel    (col_sel),
      .master_clr (master_clr),
      .sw_en      (sw_en)
   );

   // entry: [7] clear, [6] chip select, [5] data, [4:3] row, [2:0] column
   localparam int NVEC = 20;
   localparam logic [7:0] VEC [NVEC] = '{
      8'b0_1_1_00_000, 8'b0_1_1_11_111, 8'b0_1_1_01_010, 8'b0_0_1_10_100,
      8'b0_1_1_10_100, 8'b0_1_0_00_000, 8'b0_0_0_11_111, 8'b0_1_1_00_111,
      8'b0_1_1_11_000, 8'b1_0_0_00_000, 8'b0_1_1_01_101, 8'b0_1_1_10_011,
      8'b0_0_1_00_001, 8'b0_1_0_01_101, 8'b0_1_1_01_101, 8'b1_1_0_00_000,
      8'b0_1_1_11_110, 8'b0_0_0_11_110, 8'b0_1_1_00_010, 8'b0_1_0_11_110
   };

   task automatic check(input string req, input logic [31:0] exp);
      checks++;
      if (sw_en !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, sw_en, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic do_write(input logic cs, input logic d, input logic [1:0] r, input logic [2:0] c);
      chip_sel = cs; wr_data = d; row_sel = r; col_sel = c;
      idle(1);
      strobe = 1'b1;
      idle(4);
      strobe = 1'b0;
      idle(6);
      if (cs) model[int'(r) * 8 + int'(c)] = d;
   endtask

   task automatic do_clear(input logic cs);
      chip_sel = cs;
      master_clr = 1'b1;
      idle(4);
      master_clr = 1'b0;
      idle(4);
      model = '0;
   endtask

   task automatic report;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #100000;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      report();
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      check("R1", 32'h0);

      // table walk
      for (int k = 0; k < NVEC; k++) begin
         if (VEC[k][7]) begin
            do_clear(VEC[k][6]);
            check("R6", model);
         end else begin
            do_write(VEC[k][6], VEC[k][5], VEC[k][4:3], VEC[k][2:0]);
            check(VEC[k][6] ? "R2 R7" : "R3", model);
         end
      end

      // R4: nothing commits while strobe is high
      do_clear(1'b0);
      chip_sel = 1'b1; wr_data = 1'b1; row_sel = 2'd2; col_sel = 3'd5;
      idle(1);
      strobe = 1'b1;
      idle(6);
      check("R4", 32'h0);
      strobe = 1'b0;
      idle(6);
      model[21] = 1'b1;
      check("R4 R2", model);

      // R5: the data bit at the fall wins
      chip_sel = 1'b1; wr_data = 1'b0; row_sel = 2'd0; col_sel = 3'd3;
      idle(1);
      strobe = 1'b1;
      idle(2);
      wr_data = 1'b1;
      idle(3);
      strobe = 1'b0;
      idle(6);
      model[3] = 1'b1;
      check("R5", model);
      chip_sel = 1'b1; wr_data = 1'b1; row_sel = 2'd0; col_sel = 3'd3;
      idle(1);
      strobe = 1'b1;
      idle(2);
      wr_data = 1'b0;
      idle(3);
      strobe = 1'b0;
      idle(6);
      model[3] = 1'b0;
      check("R5", model);

      // R9: address is taken at the rising edge
      chip_sel = 1'b1; wr_data = 1'b1; row_sel = 2'd3; col_sel = 3'd1;
      idle(1);
      strobe = 1'b1;
      idle(4);
      row_sel = 2'd1; col_sel = 3'd6;
      idle(1);
      strobe = 1'b0;
      idle(6);
      model[25] = 1'b1;
      check("R9", model);

      // R6: clear with chip select high
      do_clear(1'b1);
      check("R6", 32'h0);

      // R8: clear together with a strobe fall
      do_write(1'b1, 1'b1, 2'd1, 3'd1);
      chip_sel = 1'b1; wr_data = 1'b1; row_sel = 2'd2; col_sel = 3'd2;
      idle(1);
      strobe = 1'b1;
      idle(4);
      strobe = 1'b0;
      master_clr = 1'b1;
      idle(4);
      master_clr = 1'b0;
      idle(4);
      model = '0;
      check("R8", 32'h0);

      // random writes and clears against the reference model
      for (int k = 0; k < 60; k++) begin
         if (($urandom % 10) == 0) begin
            do_clear(1'($urandom));
            check("R6", model);
         end else begin
            logic cs;
            cs = (($urandom % 4) != 0);
            do_write(cs, 1'($urandom), 2'($urandom), 3'($urandom));
            check(cs ? "R2 R7" : "R3", model);
         end
      end

      report();
   end

endmodule